// File: doc/BRIEF.md
# Incremental Cell Selector with Voltage Band Override

This block keeps the on/off mask for the half-bridge cells that make up one converter arm. A central controller issues a target insertion count once per control period. The block moves the mask toward that target by at most one cell per period. Which cell it switches depends on the cell voltages and on the sign of the arm current. To insert a cell while the current is charging, it picks the weakest bypassed cell. To insert a cell while the current is discharging, it picks the strongest bypassed cell. Removal follows the mirrored rule. This single min/max search over one subset replaces a full sort of every cell voltage.

On a period with no requested change, the block checks for a cell that has drifted out of its allowed band around the arm mean. If it finds one, it swaps that cell with a partner from the opposite group, so the inserted count stays the same. The block always outputs the sum of the arm's capacitor voltages, so the central controller never needs the individual voltages.

Top module: `cellsel_arm`

## Requirements
- R1: After a synchronous active-low reset, the mask is all zeros, the applied count is 0, the error flag is clear and the reported voltage sum is 0.
- R2: The mask, the applied count and the error flag change only at a clock edge where `strobe` is high.
- R3: On a strobe where the saturated request equals the applied count and no cell violates the band, the mask is unchanged.
- R4: On a strobe where the request is above the applied count, exactly one bypassed cell is turned on. It is the one with the lowest voltage when `cur_pos` is 1 (charging) and the one with the highest voltage when `cur_pos` is 0. The applied count rises by one.
- R5: On a strobe where the request is below the applied count, exactly one inserted cell is turned off. It is the one with the highest voltage when `cur_pos` is 1 and the one with the lowest voltage when `cur_pos` is 0. The applied count falls by one.
- R6: When several candidate cells share the extreme voltage, the cell with the lowest number wins. Cell i has its voltage in bits [i*VW +: VW] of `cell_v` and its state in bit i of `cell_on`.
- R7: A request above N is treated as N. A request more than one step away from the applied count is clamped to one step in its direction. Either case sets `step_err`, which stays set until reset.
- R8: Cell i is out of band when the arm sum S is non-zero and |N*v_i - S| * 100 >= S, that is, when its deviation from the mean S/N is at least 1% of the mean.
- R9: On a strobe where the saturated request equals the applied count and at least one cell is out of band, the lowest-numbered violating cell is toggled. A partner is toggled with it so the count is preserved. If the violator is inserted, the partner is the bypassed cell chosen by the R4 rule. If the violator is bypassed, the partner is the inserted cell chosen by the R5 rule. If no partner exists, nothing changes.
- R10: The number of ones in the mask always equals the applied count. A strobe with no band violation toggles at most one cell.
- R11: `arm_sum` equals the sum of all cell voltages sampled at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strobe | input | 1 | One-cycle pulse marking a control period update |
| idx_req | input | $clog2(N+1) | Requested insertion count |
| cur_pos | input | 1 | Arm current sign: 1 charging, 0 discharging |
| cell_v | input | N*VW | Cell capacitor voltages, cell i at [i*VW +: VW] |
| cell_on | output | N | Insertion mask, bit i = cell i inserted |
| idx_applied | output | $clog2(N+1) | Insertion count currently applied |
| step_err | output | 1 | Sticky flag for a saturated or clamped request |
| arm_sum | output | VW+$clog2(N+1) | Registered sum of the cell voltages |

## Verification
The assertions assume the following about the inputs:
- `cell_v` and `cur_pos` are stable across the edge at which `strobe` is sampled.
- The mask starts from reset, so the count invariant holds from the first edge onward.
- `strobe` can arrive on any cycle.

The stimulus drives all inputs on the falling edge and raises `strobe` for a single cycle. It keeps voltages non-zero after reset. It also holds them for a full cycle before each sample, so that the registered sum and the band decision both see the same values as the reference model.

The sweep covers the following, on a four-cell arm:
- equal voltages, to exercise tie-breaking;
- ordered voltages, to exercise min/max steering under both current signs;
- jumps and out-of-range requests, to exercise clamping;
- injected outliers, to exercise band swaps.

// File: rtl/cellsel_pkg.sv
// Package: shared types for the arm cell selector.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package cellsel_pkg;
    // Direction of the per-period count change.
    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_e;
endpackage

// File: rtl/cellsel_pick.sv
// Module: cellsel_pick
// Finds the eligible cell with the lowest (or highest) voltage.
// Ties resolve to the lowest cell number.
// Assumes voltages are unsigned and packed VW bits per cell, cell 0 in the LSBs.
module cellsel_pick #(
    parameter int N_CELLS = 8,
    parameter int VW      = 12,
    localparam int SELW   = (N_CELLS > 1) ? $clog2(N_CELLS) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_CELLS*VW-1:0]   volts,
    input  logic [N_CELLS-1:0]      elig,
    input  logic                    want_max,
    output logic [SELW-1:0]         sel,
    output logic                    found
);
    logic [VW-1:0] best;

    // Linear scan; a strict comparison keeps the earliest index on ties.
    always_comb begin
        found = 1'b0;
        sel   = '0;
        best  = '0;
        for (int i = 0; i < N_CELLS; i++) begin
            if (elig[i] && (!found ||
                (want_max ? (volts[i*VW +: VW] > best) : (volts[i*VW +: VW] < best)))) begin
                found = 1'b1;
                sel   = SELW'(i);
                best  = volts[i*VW +: VW];
            end
        end
    end

    // R4/R5: a reported choice must come from the eligible subset.
    p_pick_eligible_r4: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> elig[sel]);
    // R6: any non-empty subset yields a choice.
    p_pick_found_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (elig != '0) |-> found);
endmodule

// File: rtl/cellsel_band.sv
// Module: cellsel_band
// Sums the cell voltages and flags cells whose deviation from the arm mean
// reaches 1% of that mean. The check is done without division:
//     |N*v - S| * 100 >= S
// Also reports the lowest-numbered violator.
// Assumes an all-zero arm (S == 0) is never treated as a violation.
module cellsel_band #(
    parameter int N_CELLS = 8,
    parameter int VW      = 12,
    localparam int SW     = VW + $clog2(N_CELLS + 1),
    localparam int CW     = SW + 8,
    localparam int SELW   = (N_CELLS > 1) ? $clog2(N_CELLS) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_CELLS*VW-1:0]   volts,
    output logic [SW-1:0]           sum_o,
    output logic                    viol_any,
    output logic [SELW-1:0]         viol_sel
);
    logic [N_CELLS-1:0] viol;

    // Arm voltage sum.
    always_comb begin
        sum_o = '0;
        for (int i = 0; i < N_CELLS; i++) sum_o = sum_o + SW'(volts[i*VW +: VW]);
    end

    // One band comparator per cell.
    for (genvar g = 0; g < N_CELLS; g++) begin : g_cell
        logic [CW-1:0] scaled, dev;
        // Scaled deviation of this cell from the mean, kept in integer form.
        always_comb begin
            scaled  = CW'(N_CELLS) * CW'(volts[g*VW +: VW]);
            dev     = (scaled >= CW'(sum_o)) ? scaled - CW'(sum_o) : CW'(sum_o) - scaled;
            viol[g] = (sum_o != '0) && (dev * CW'(100) >= CW'(sum_o));
        end
    end

    // Lowest-numbered violator.
    always_comb begin
        viol_any = 1'b0;
        viol_sel = '0;
        for (int i = N_CELLS - 1; i >= 0; i--) begin
            if (viol[i]) begin
                viol_any = 1'b1;
                viol_sel = SELW'(i);
            end
        end
    end

    // R8: the chosen violator must itself be flagged.
    p_viol_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
        viol_any |-> viol[viol_sel]);
endmodule

// File: rtl/cellsel_arm.sv
// Module: cellsel_arm (top)
// Keeps the insertion mask of one arm.
// On each strobe it does exactly one of the following:
//   - moves the inserted count by at most one, choosing the cell by min/max
//     voltage according to the current sign;
//   - on a hold period, swaps an out-of-band cell with a partner so the count
//     is preserved.
// Also registers the arm voltage sum for the central controller.
// Assumes cell_v and cur_pos are stable at the strobe edge.
module cellsel_arm
    import cellsel_pkg::*;
#(
    parameter int N_CELLS = 8,
    parameter int VW      = 12,
    localparam int IW     = $clog2(N_CELLS + 1),
    localparam int SW     = VW + $clog2(N_CELLS + 1),
    localparam int SELW   = (N_CELLS > 1) ? $clog2(N_CELLS) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    strobe,
    input  logic [IW-1:0]           idx_req,
    input  logic                    cur_pos,
    input  logic [N_CELLS*VW-1:0]   cell_v,
    output logic [N_CELLS-1:0]      cell_on,
    output logic [IW-1:0]           idx_applied,
    output logic                    step_err,
    output logic [SW-1:0]           arm_sum
);
    logic [SW-1:0]      sum_now;
    logic               band_any;
    logic [SELW-1:0]    band_sel;
    logic [SELW-1:0]    up_sel, dn_sel;
    logic               up_found, dn_found;
    logic [IW:0]        tgt_sat;
    logic               over_range, jump;
    step_e              dir;
    logic [N_CELLS-1:0] mask_nx;
    logic [IW-1:0]      app_nx;
    logic               err_nx;

    cellsel_band #(.N_CELLS(N_CELLS), .VW(VW)) band_i (
        .clk(clk), .rst_n(rst_n), .volts(cell_v),
        .sum_o(sum_now), .viol_any(band_any), .viol_sel(band_sel)
    );

    // Insert candidate: among bypassed cells, lowest when charging, highest otherwise.
    cellsel_pick #(.N_CELLS(N_CELLS), .VW(VW)) pick_up_i (
        .clk(clk), .rst_n(rst_n), .volts(cell_v), .elig(~cell_on),
        .want_max(~cur_pos), .sel(up_sel), .found(up_found)
    );

    // Remove candidate: among inserted cells, highest when charging, lowest otherwise.
    cellsel_pick #(.N_CELLS(N_CELLS), .VW(VW)) pick_dn_i (
        .clk(clk), .rst_n(rst_n), .volts(cell_v), .elig(cell_on),
        .want_max(cur_pos), .sel(dn_sel), .found(dn_found)
    );

    // Saturate the request to N and derive the step direction and error cases.
    always_comb begin
        over_range = ({1'b0, idx_req} > (IW+1)'(N_CELLS));
        tgt_sat    = over_range ? (IW+1)'(N_CELLS) : {1'b0, idx_req};
        if (tgt_sat > {1'b0, idx_applied}) begin
            dir  = STEP_UP;
            jump = tgt_sat > ({1'b0, idx_applied} + 1'b1);
        end else if (tgt_sat < {1'b0, idx_applied}) begin
            dir  = STEP_DOWN;
            jump = ({1'b0, idx_applied} - tgt_sat) > (IW+1)'(1);
        end else begin
            dir  = STEP_HOLD;
            jump = 1'b0;
        end
    end

    // Next mask: a single step, or a count-preserving band swap on hold.
    always_comb begin
        mask_nx = cell_on;
        app_nx  = idx_applied;
        err_nx  = step_err | over_range | jump;
        unique case (dir)
            STEP_UP: if (up_found) begin
                mask_nx[up_sel] = 1'b1;
                app_nx          = idx_applied + 1'b1;
            end
            STEP_DOWN: if (dn_found) begin
                mask_nx[dn_sel] = 1'b0;
                app_nx          = idx_applied - 1'b1;
            end
            default: if (band_any) begin
                if (cell_on[band_sel] && up_found) begin
                    mask_nx[band_sel] = 1'b0;
                    mask_nx[up_sel]   = 1'b1;
                end else if (!cell_on[band_sel] && dn_found) begin
                    mask_nx[band_sel] = 1'b1;
                    mask_nx[dn_sel]   = 1'b0;
                end
            end
        endcase
    end

    // State registers: sum every cycle, mask state only on strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cell_on     <= '0;
            idx_applied <= '0;
            step_err    <= 1'b0;
            arm_sum     <= '0;
        end else begin
            arm_sum <= sum_now;
            if (strobe) begin
                cell_on     <= mask_nx;
                idx_applied <= app_nx;
                step_err    <= err_nx;
            end
        end
    end

    p_mask_only_on_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> ($stable(cell_on) && $stable(idx_applied) && $stable(step_err)));

    p_count_matches_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(cell_on) == int'(idx_applied));

    p_one_toggle_no_band_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !band_any) |=> ($countones(cell_on ^ $past(cell_on)) <= 1));

    p_single_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> ((idx_applied == $past(idx_applied)) ||
                    (idx_applied == $past(idx_applied) + 1'b1) ||
                    (idx_applied == $past(idx_applied) - 1'b1)));

    p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        step_err |=> step_err);

    p_band_keeps_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && dir == STEP_HOLD) |=> (idx_applied == $past(idx_applied)));
endmodule

// File: tb/cellsel_arm_tb_top.sv
module cellsel_arm_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 4;
    localparam int VW = 10;
    localparam int IW = $clog2(N + 1);
    localparam int SW = VW + $clog2(N + 1);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            strobe = 1'b0;
    logic [IW-1:0]   idx_req = '0;
    logic            cur_pos = 1'b0;
    logic [N*VW-1:0] cell_v;
    logic [N-1:0]    cell_on;
    logic [IW-1:0]   idx_applied;
    logic            step_err;
    logic [SW-1:0]   arm_sum;

    int v [N];
    int m_mask, m_app, m_err;
    int n_checks = 0, n_fail = 0;
    int unsigned rng = 32'h1234_5678;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb
        for (int i = 0; i < N; i++) cell_v[i*VW +: VW] = VW'(v[i]);

    cellsel_arm #(.N_CELLS(N), .VW(VW)) dut_i (
        .clk(clk), .rst_n(rst_n), .strobe(strobe), .idx_req(idx_req),
        .cur_pos(cur_pos), .cell_v(cell_v), .cell_on(cell_on),
        .idx_applied(idx_applied), .step_err(step_err), .arm_sum(arm_sum)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int vsum();
        int s = 0;
        for (int i = 0; i < N; i++) s += v[i];
        return s;
    endfunction

    // Index of the extreme cell in the eligible set; -1 when the set is empty.
    function automatic int pick(input int elig, input bit want_max);
        int k = -1;
        for (int i = 0; i < N; i++)
            if (elig[i] && (k < 0 || (want_max ? v[i] > v[k] : v[i] < v[k]))) k = i;
        return k;
    endfunction

    function automatic int first_viol();
        int s = vsum();
        for (int i = 0; i < N; i++) begin
            int d = N * v[i] - s;
            if (d < 0) d = -d;
            if (s != 0 && d * 100 >= s) return i;
        end
        return -1;
    endfunction

    // Reference model of one strobe, built from the requirements.
    task automatic model_step(input int req, input bit pos);
        int full = (1 << N) - 1;
        int sat  = (req > N) ? N : req;
        int c, f;
        if (req > N) m_err = 1;
        if (sat > m_app) begin
            if (sat > m_app + 1) m_err = 1;
            c = pick(~m_mask & full, !pos);
            if (c >= 0) begin m_mask |= (1 << c); m_app++; end
        end else if (sat < m_app) begin
            if (sat < m_app - 1) m_err = 1;
            c = pick(m_mask, pos);
            if (c >= 0) begin m_mask &= ~(1 << c); m_app--; end
        end else begin
            f = first_viol();
            if (f >= 0) begin
                if (m_mask[f]) c = pick(~m_mask & full, !pos);
                else           c = pick(m_mask, pos);
                if (c >= 0) m_mask ^= (1 << f) | (1 << c);
            end
        end
    endtask

    task automatic do_period(input int req, input bit pos, input string tag);
        @(negedge clk);
        idx_req = IW'(req);
        cur_pos = pos;
        strobe  = 1'b1;
        model_step(req, pos);
        @(negedge clk);
        strobe = 1'b0;
        check(int'(cell_on) == m_mask, tag, int'(cell_on), m_mask);
        check(int'(idx_applied) == m_app, "R10 count", int'(idx_applied), m_app);
        check(int'(step_err) == m_err, "R7 err flag", int'(step_err), m_err);
        check($countones(cell_on) == int'(idx_applied), "R10 popcount",
              $countones(cell_on), int'(idx_applied));
        check(int'(arm_sum) == vsum(), "R11 sum", int'(arm_sum), vsum());
    endtask

    function automatic int rnd(input int m);
        rng ^= rng << 13;
        rng ^= rng >> 17;
        rng ^= rng << 5;
        return int'(rng % m);
    endfunction

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) v[i] = 0;
        m_mask = 0;
        m_app  = 0;
        m_err  = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(cell_on == '0, "R1 mask", int'(cell_on), 0);
        check(idx_applied == '0, "R1 count", int'(idx_applied), 0);
        check(step_err == 1'b0, "R1 err", int'(step_err), 0);
        check(arm_sum == '0, "R1 sum", int'(arm_sum), 0);

        // R6: equal voltages, so ties go to the lowest cell number
        for (int i = 0; i < N; i++) v[i] = 500;
        do_period(1, 1, "R6 tie insert charging");
        do_period(2, 0, "R6 tie insert discharging");
        do_period(1, 1, "R6 tie remove");
        // R3: hold with no violation
        do_period(1, 0, "R3 hold");

        // R4 / R5: ordered voltages, both current signs
        v[0] = 503; v[1] = 497; v[2] = 501; v[3] = 499;
        do_period(2, 1, "R4 insert lowest charging");
        do_period(3, 0, "R4 insert highest discharging");
        do_period(2, 1, "R5 remove highest charging");
        do_period(1, 0, "R5 remove lowest discharging");

        // R7: jumps and saturation
        do_period(4, 1, "R7 clamp up");
        do_period(7, 0, "R7 saturate above N");
        do_period(0, 1, "R7 clamp down");

        // R2: no strobe, so no change
        @(negedge clk);
        idx_req = IW'(4);
        v[2] = 560;
        repeat (3) @(negedge clk);
        check(int'(cell_on) == m_mask, "R2 no strobe mask", int'(cell_on), m_mask);
        check(int'(idx_applied) == m_app, "R2 no strobe count", int'(idx_applied), m_app);

        // R8 / R9: violator bypassed, then inserted
        do_period(m_app, 1, "R9 band swap on bypassed violator");
        v[2] = 500; v[0] = 440;
        do_period(m_app, 0, "R8 R9 band swap low outlier");

        // R9: no partner available (all cells inserted), nothing changes
        for (int i = 0; i < N; i++) v[i] = 500;
        do_period(3, 1, "R4 fill");
        do_period(4, 1, "R4 fill");
        v[1] = 600;
        do_period(4, 1, "R9 no partner");

        // Sweep: random steps, current signs and outliers
        for (int t = 0; t < 500; t++) begin
            int req;
            for (int i = 0; i < N; i++) v[i] = 497 + rnd(7);
            if (rnd(4) == 0) v[rnd(N)] = 460 + rnd(80);
            req = m_app + rnd(7) - 3;
            if (req < 0) req = 0;
            if (req > 7) req = 7;
            do_period(req, rnd(2) == 1, "R3 R4 R5 R8 R9 sweep");
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule